// File: doc/BRIEF.md
# Platform-Level Interrupt Router

This block collects level-sensitive interrupt lines from a parameterised set of sources and steers them to a small number of target contexts. Each context sees one registered request output. Software programs a 3-bit priority per source, a per-context enable bitmap and a per-context priority threshold through a simple synchronous register port: address, write data, write strobe, read strobe and registered read data.

A context services a request in two steps. It reads its claim/complete register to learn which source won and to retire that source's pending bit. It then writes the same source ID back to that register once the handler is done. Between those two steps the source is held off: a line that stays high is not accepted again. After the write-back, the source's gateway is re-armed. Source ID 0 is reserved and a claim result of 0 means that nothing is waiting.

The default build has 32 source slots (31 usable) and two contexts. A write and a read must not be issued in the same cycle; if both strobes are high, the write is performed and the read is dropped.

Top module: `irqRouter`

## Requirements
- R1: Source ID 0 is reserved. Its priority reads 0 whatever is written, bit 0 of every context's first enable word reads 0, and it never wins a claim. A claim read that returns 0 means no source is eligible.
- R2: Register map, byte addresses with 32-bit data:
  - Source N's priority is at 4*N.
  - Context C's enable words start at 0x2000 + 0x80*C. Source N's enable bit is bit N mod 32 of word N/32.
  - Context C's threshold is at 0x200000 + 0x1000*C, and its claim/complete register is at that address + 4.
  - Priority and threshold keep the low 3 bits of a write and read back zero-extended.
  - Reads of unmapped addresses return 0.
- R3: A source is eligible for a context when it is pending, enabled for that context and its priority is strictly greater than the context's threshold. The context's request output is registered. It is high one cycle after eligibility exists, so it rises on the second rising edge after a line goes high.
- R4: A threshold of 7 keeps a context's request low for every source. A priority of 0 never raises a request, even with a threshold of 0.
- R5: Among eligible sources the higher priority wins a claim. On equal priority the lower source ID wins.
- R6: Read data is valid in the cycle after the read strobe. A claim read returns the winner for that context and clears its pending bit at the same edge, so claims on consecutive cycles return distinct IDs.
- R7: A claimed source cannot become pending again before it is completed, even while its line stays high.
- R8: Writing the claimed ID to the claim/complete register of a context that has the source enabled completes it. A line that is still high then makes the source pending again. A line that is low leaves it idle.
- R9: A completion write is ignored, leaving the source held off, when:
  - the ID is not currently claimed;
  - the source is not enabled for the addressed context;
  - the ID is 0 or out of range.
- R10: A pending bit, once set, stays set when the line drops, until the source is claimed.
- R11: After reset all priorities, enables, thresholds, pending and claimed state are 0 and every request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWdata | input | 32 | Write data |
| regWr | input | 1 | Write strobe, one access per cycle |
| regRd | input | 1 | Read strobe; a claim read takes effect at the following edge |
| regRdata | output | 32 | Read data, registered, valid the cycle after regRd |
| irqIn | input | NUM_SRC | Level-sensitive source lines, bit N is source N (bit 0 unused) |
| irqOut | output | NUM_CTX | Registered interrupt request per context |

## Verification
Two events can meet at one clock edge: the gateway accepting a newly raised line, and a claim read retiring a different source. The bench raises a higher-priority line in the very cycle the read strobe of a claim is high. It then expects that claim to return the older, lower-priority source, because the new line was not yet pending when the winner was sampled. It expects the claim issued on the next cycle to return the new source. This shows that the two updates to the pending vector at that edge neither mask nor merge with each other.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // widest fields the decoder can hand over; the core slices what it needs
  localparam int IDX_W  = 11;
  localparam int CTXF_W = 14;
  localparam int WORD_W = 5;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_PRIO,
    RD_ENABLE,
    RD_THRESH,
    RD_CLAIM
  } rdSel_e;

  typedef struct packed {
    logic               wrPrio;
    logic               wrEnable;
    logic               wrThresh;
    logic               wrComplete;
    logic               rdStrobe;
    rdSel_e             rdSel;
    logic [IDX_W-1:0]   srcIdx;
    logic [WORD_W-1:0]  wordIdx;
    logic [CTXF_W-1:0]  ctxIdx;
  } regCmd_t;

endpackage

// File: rtl/irqRegDecode.sv
module irqRegDecode
  import irq_router_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  output regCmd_t           cmd
);

  localparam int EN_WORDS = (NUM_SRC + 31) / 32;
  localparam logic [ADDR_W-1:0] EN_BASE  = ADDR_W'(32'h0000_2000);
  localparam logic [ADDR_W-1:0] CTL_BASE = ADDR_W'(32'h0020_0000);
  localparam logic [ADDR_W-1:0] SRC_LIM  = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] CTX_LIM  = ADDR_W'(NUM_CTX);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] unitIdx;

  always_comb begin
    cmd          = '0;
    cmd.rdSel    = RD_ZERO;
    offset       = '0;
    unitIdx      = '0;
    // a write takes precedence; a read in the same cycle is dropped
    cmd.rdStrobe = regRd && !regWr;
    if (regAddr < EN_BASE) begin
      unitIdx = regAddr >> 2;
      if (unitIdx < SRC_LIM) begin
        cmd.srcIdx = IDX_W'(unitIdx);
        cmd.wrPrio = regWr;
        cmd.rdSel  = RD_PRIO;
      end
    end else if (regAddr < CTL_BASE) begin
      offset  = regAddr - EN_BASE;
      unitIdx = offset >> 7;
      if ((unitIdx < CTX_LIM) && ({1'b0, offset[6:2]} < 6'(EN_WORDS))) begin
        cmd.ctxIdx   = CTXF_W'(unitIdx);
        cmd.wordIdx  = offset[6:2];
        cmd.wrEnable = regWr;
        cmd.rdSel    = RD_ENABLE;
      end
    end else begin
      offset  = regAddr - CTL_BASE;
      unitIdx = offset >> 12;
      if (unitIdx < CTX_LIM) begin
        cmd.ctxIdx = CTXF_W'(unitIdx);
        if (offset[11:0] == 12'h000) begin
          cmd.wrThresh = regWr;
          cmd.rdSel    = RD_THRESH;
        end else if (offset[11:0] == 12'h004) begin
          cmd.wrComplete = regWr;
          cmd.rdSel      = RD_CLAIM;
        end
      end
    end
  end

  // R2
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.wrPrio, cmd.wrEnable, cmd.wrThresh, cmd.wrComplete,
              cmd.rdStrobe && (cmd.rdSel == RD_CLAIM)}));

endmodule

// File: rtl/irqCore.sv
module irqCore
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  regCmd_t            cmd,
  input  logic [31:0]        wdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [NUM_CTX-1:0] irqOut,
  output logic [31:0]        rdata
);

  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int EN_WORDS = (NUM_SRC + 31) / 32;
  localparam int EN_BITS  = EN_WORDS * 32;

  function automatic logic [EN_BITS-1:0] validMask();
    logic [EN_BITS-1:0] m;
    for (int i = 0; i < EN_BITS; i++) m[i] = (i >= 1) && (i < NUM_SRC);
    return m;
  endfunction

  localparam logic [EN_BITS-1:0] EN_MASK = validMask();

  logic [PRIO_W-1:0]  prio    [NUM_SRC];
  logic [EN_BITS-1:0] enable  [NUM_CTX];
  logic [PRIO_W-1:0]  thresh  [NUM_CTX];
  logic [NUM_SRC-1:0] pending, inFlight;
  logic [NUM_SRC-1:0] pendNext, flightNext;
  logic [SRC_W-1:0]   winId   [NUM_CTX];
  logic [NUM_CTX-1:0] winValid;

  logic [SRC_W-1:0] sIdx;
  logic [CTX_W-1:0] cIdx;
  int               wIdx;
  logic             claimHit;
  logic [SRC_W-1:0] claimId;
  logic [SRC_W-1:0] doneId;
  logic             doneOk;

  assign sIdx    = cmd.srcIdx[SRC_W-1:0];
  assign cIdx    = cmd.ctxIdx[CTX_W-1:0];
  assign wIdx    = int'(cmd.wordIdx);
  assign claimId = winId[cIdx];
  assign claimHit = cmd.rdStrobe && (cmd.rdSel == RD_CLAIM) && winValid[cIdx];
  assign doneId  = wdata[SRC_W-1:0];
  assign doneOk  = cmd.wrComplete && (wdata < 32'(NUM_SRC)) && (doneId != '0)
                   && inFlight[doneId] && enable[cIdx][doneId];

  // per-context arbitration: strict compare keeps the lowest ID on a tie
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_arb
    logic [PRIO_W-1:0] bestPrio;
    logic [SRC_W-1:0]  bestId;
    logic              found;
    always_comb begin
      bestPrio = '0;
      bestId   = '0;
      found    = 1'b0;
      for (int s = 1; s < NUM_SRC; s++) begin
        if (pending[s] && enable[c][s] && (prio[s] > thresh[c]) &&
            (!found || (prio[s] > bestPrio))) begin
          found    = 1'b1;
          bestPrio = prio[s];
          bestId   = SRC_W'(s);
        end
      end
    end
    assign winId[c]    = bestId;
    assign winValid[c] = found;

    // R4
    mask_all_chk: assert property (@(posedge clk) disable iff (!rstN)
      (thresh[c] == '1) |=> !irqOut[c]);
  end

  // gateway: accept a level only when idle, retire on claim, re-arm on completion
  always_comb begin
    pendNext   = pending;
    flightNext = inFlight;
    for (int s = 1; s < NUM_SRC; s++) begin
      if (irqIn[s] && !pending[s] && !inFlight[s]) pendNext[s] = 1'b1;
    end
    if (claimHit) begin
      pendNext[claimId]   = 1'b0;
      flightNext[claimId] = 1'b1;
    end
    if (doneOk) flightNext[doneId] = 1'b0;
    pendNext[0]   = 1'b0;
    flightNext[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= '0;
      inFlight <= '0;
      irqOut   <= '0;
    end else begin
      pending  <= pendNext;
      inFlight <= flightNext;
      irqOut   <= winValid;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SRC; s++) prio[s] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        enable[c] <= '0;
        thresh[c] <= '0;
      end
    end else begin
      if (cmd.wrPrio && (sIdx != '0)) prio[sIdx] <= wdata[PRIO_W-1:0];
      if (cmd.wrEnable)
        enable[cIdx][wIdx*32 +: 32] <= wdata & EN_MASK[wIdx*32 +: 32];
      if (cmd.wrThresh) thresh[cIdx] <= wdata[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (cmd.rdStrobe) begin
      case (cmd.rdSel)
        RD_PRIO:   rdata <= 32'(prio[sIdx]);
        RD_ENABLE: rdata <= enable[cIdx][wIdx*32 +: 32];
        RD_THRESH: rdata <= 32'(thresh[cIdx]);
        RD_CLAIM:  rdata <= claimHit ? 32'(claimId) : 32'd0;
        default:   rdata <= '0;
      endcase
    end
  end

  // R6
  claim_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    claimHit |=> (!pending[$past(claimId)] && inFlight[$past(claimId)]));

  // R7
  held_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending & inFlight) == '0);

  // R9
  stale_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrComplete && !doneOk) |=> (inFlight == $past(inFlight)));

endmodule

// File: rtl/irqRouter.sv
module irqRouter
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  input  logic               regWr,
  input  logic               regRd,
  output logic [31:0]        regRdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [NUM_CTX-1:0] irqOut
);

  regCmd_t cmd;

  irqRegDecode #(
    .ADDR_W (ADDR_W),
    .NUM_SRC(NUM_SRC),
    .NUM_CTX(NUM_CTX)
  ) u_decode (
    .clk    (clk),
    .rstN   (rstN),
    .regAddr(regAddr),
    .regWr  (regWr),
    .regRd  (regRd),
    .cmd    (cmd)
  );

  irqCore #(
    .NUM_SRC(NUM_SRC),
    .NUM_CTX(NUM_CTX),
    .PRIO_W (PRIO_W)
  ) u_core (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .wdata (regWdata),
    .irqIn (irqIn),
    .irqOut(irqOut),
    .rdata (regRdata)
  );

endmodule

// File: tb/test_irqRouter.sv
module test_irqRouter;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;
  localparam int NCTX = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [23:0]       regAddr = '0;
  logic [31:0]       regWdata = '0;
  logic              regWr = 1'b0;
  logic              regRd = 1'b0;
  logic [31:0]       regRdata;
  logic [NSRC-1:0]   irqIn = '0;
  logic [NCTX-1:0]   irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  irqRouter #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PRIO_W(3), .ADDR_W(24)) i_irqRouter (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWr(regWr), .regRd(regRd), .regRdata(regRdata),
    .irqIn(irqIn), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] prioA(int id); return 24'(4*id); endfunction
  function automatic logic [23:0] enA(int c, int w); return 24'(32'h2000 + 32'h80*c + 4*w); endfunction
  function automatic logic [23:0] thrA(int c); return 24'(32'h20_0000 + 32'h1000*c); endfunction
  function automatic logic [23:0] clmA(int c); return 24'(32'h20_0000 + 32'h1000*c + 4); endfunction
  function automatic int prioOf(int id); return (id % 7) + 1; endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic busRead(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // expected winner among pending, not-taken sources on the 31-source sweep
  function automatic int nextWinner(input bit [NSRC-1:0] taken);
    int best = 0;
    int bestP = 0;
    for (int id = 1; id < NSRC; id++)
      if (!taken[id] && prioOf(id) > bestP) begin best = id; bestP = prioOf(id); end
    return best;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit [NSRC-1:0] taken;
    int expId;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 irqOut", 32'(irqOut), 0);
    busRead(prioA(5), d);   check("R11 prio", d, 0);
    busRead(thrA(1), d);    check("R11 thresh", d, 0);
    busRead(enA(0, 0), d);  check("R11 enable", d, 0);
    busRead(clmA(0), d);    check("R1 empty claim", d, 0);

    // R1 / R2 reserved source and register fields
    busWrite(prioA(0), 7);
    busRead(prioA(0), d);   check("R1 prio0", d, 0);
    busWrite(enA(0, 0), 32'hFFFF_FFFF);
    busRead(enA(0, 0), d);  check("R1 enable bit0", d, 32'hFFFF_FFFE);
    busWrite(prioA(31), 32'hFFFF_FFFD);
    busRead(prioA(31), d);  check("R2 prio width", d, 5);
    busWrite(thrA(1), 32'hFF);
    busRead(thrA(1), d);    check("R2 thresh width", d, 7);
    busRead(24'h10_0000, d); check("R2 unmapped enable ctx", d, 0);
    busRead(thrA(0) + 24'd8, d); check("R2 unmapped ctl", d, 0);
    busWrite(thrA(1), 0);
    busWrite(prioA(31), 0);

    // R3 / R4 priority-threshold sweep on source 3, ctx0 only
    busWrite(enA(0, 0), 32'h1 << 3);
    irqIn[3] = 1'b1;
    for (int p = 0; p < 8; p++) begin
      for (int t = 0; t < 8; t++) begin
        busWrite(prioA(3), 32'(p));
        busWrite(thrA(0), 32'(t));
        settle();
        check($sformatf("R3 R4 ctx0 p=%0d t=%0d", p, t), 32'(irqOut[0]), 32'(p > t));
        check("R3 ctx1 not enabled", 32'(irqOut[1]), 0);
      end
    end

    // R6 R7 R8 claim/complete on a steady level
    busWrite(prioA(3), 5);
    busWrite(thrA(0), 0);
    settle();
    busRead(clmA(0), d);    check("R6 claim id", d, 3);
    settle();
    check("R7 held while claimed", 32'(irqOut[0]), 0);
    busRead(clmA(0), d);    check("R7 no re-claim", d, 0);
    busWrite(clmA(0), 3);
    settle();
    check("R8 re-pend high line", 32'(irqOut[0]), 1);
    busRead(clmA(0), d);    check("R8 claim again", d, 3);
    irqIn[3] = 1'b0;
    busWrite(clmA(0), 3);
    settle();
    check("R8 low line idle", 32'(irqOut[0]), 0);
    busWrite(enA(0, 0), 0);

    // R5 R6 full arbitration sweep on ctx1, back-to-back claims
    for (int id = 1; id < NSRC; id++) busWrite(prioA(id), 32'(prioOf(id)));
    busWrite(enA(1, 0), 32'hFFFF_FFFF);
    irqIn = '1;
    settle();
    check("R3 ctx1 raised", 32'(irqOut[1]), 1);
    taken = '0;
    for (int k = 0; k < NSRC - 1; k++) begin
      expId = nextWinner(taken);
      busRead(clmA(1), d);
      check($sformatf("R5 R6 claim order k=%0d", k), d, 32'(expId));
      taken[expId] = 1'b1;
    end
    busRead(clmA(1), d);    check("R1 all claimed", d, 0);
    settle();
    check("R7 ctx1 low", 32'(irqOut[1]), 0);
    for (int id = 1; id < NSRC; id++) busWrite(clmA(1), 32'(id));
    settle();
    check("R8 ctx1 re-raised", 32'(irqOut[1]), 1);
    // R10 lines drop; pending bits persist and are claimed in the same order
    irqIn = '0;
    settle();
    taken = '0;
    for (int k = 0; k < NSRC - 1; k++) begin
      expId = nextWinner(taken);
      busRead(clmA(1), d);
      check($sformatf("R10 latched claim k=%0d", k), d, 32'(expId));
      taken[expId] = 1'b1;
    end
    for (int id = 1; id < NSRC; id++) busWrite(clmA(1), 32'(id));
    settle();
    check("R10 drained", 32'(irqOut[1]), 0);

    // R9 ignored completions, source 7 on ctx1 only
    busWrite(enA(1, 0), 32'h1 << 7);
    irqIn[7] = 1'b1;
    settle();
    busRead(clmA(1), d);    check("R9 setup claim", d, 7);
    busWrite(clmA(0), 7);   // ctx0 does not enable source 7
    settle();
    check("R9 wrong context", 32'(irqOut[1]), 0);
    busRead(clmA(1), d);    check("R9 wrong context claim", d, 0);
    busWrite(clmA(1), 8);   // not claimed
    settle();
    check("R9 unclaimed id", 32'(irqOut[1]), 0);
    busWrite(clmA(1), 0);
    settle();
    check("R9 id zero", 32'(irqOut[1]), 0);
    busWrite(clmA(1), 7);
    settle();
    check("R9 R8 proper completion", 32'(irqOut[1]), 1);
    busRead(clmA(1), d);    check("R8 reclaim 7", d, 7);
    irqIn[7] = 1'b0;
    busWrite(clmA(1), 7);
    settle();

    // R6 claim and gateway accept on the same edge
    busWrite(enA(1, 0), (32'h1 << 9) | (32'h1 << 12));
    irqIn[9] = 1'b1;
    settle();
    @(negedge clk);
    regAddr = clmA(1); regRd = 1'b1; irqIn[12] = 1'b1;
    @(negedge clk);
    check("R6 same-edge claim old", regRdata, 9);
    @(negedge clk);
    regRd = 1'b0;
    check("R6 next-cycle claim new", regRdata, 12);
    irqIn = '0;
    busWrite(clmA(1), 9);
    busWrite(clmA(1), 12);
    settle();
    check("R8 final idle", 32'(irqOut), 0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule